// File: doc/BRIEF.md
# Valley Lockout Mode Selector

This block chooses the operating point of a quasi-resonant flyback controller from its feedback level. It picks the drain-voltage valley in which the power switch turns on (first to fourth), or, at the lightest loads, a variable-frequency oscillator mode. Each step between neighbouring modes has its own falling and rising threshold. The chosen mode therefore stays put until the feedback moves well away from the level that caused the last step.

The feedback voltage arrives as an unsigned millivolt code. It is evaluated only when `cycle_start` is high, once per switching period. The selector holds its mode in a state register. It drives four outputs: a one-hot valley select, an oscillator-mode flag, a peak-current setpoint code, and the oscillator charge threshold code used in oscillator mode.

Top module: `valley_lockout_sel`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become `valley`=4'b0001 (bit 0 is the 1st valley, bit 3 the 4th), `vco_mode`=0, `setpoint_mv`=0 and `vco_thresh_mv`=0. The mode is the 1st valley.
- R2: The mode and all outputs change only at a clock edge where `cycle_start` is high. The result is visible after that edge. With `cycle_start` low, changing `fb_mv` has no effect on any output.
- R3: Falling steps are taken when fb_mv is strictly below the step's level: 1st→2nd below 1400, 2nd→3rd below 1200, 3rd→4th below 900, 4th→oscillator below 800.
- R4: Rising steps are taken when fb_mv is strictly above the step's level: oscillator→4th above 1400, 4th→3rd above 1600, 3rd→2nd above 1800, 2nd→1st above 2000.
- R5: One evaluation moves the mode by at most one neighbouring step, even when the sample lies beyond several thresholds.
- R6: A sample between a mode's falling and rising levels (equal values included) leaves the mode unchanged.
- R7: In a valley mode, `setpoint_mv` = min(floor(fb_mv/4), 800). It is computed from the sample evaluated at the same edge.
- R8: In oscillator mode, `vco_mode`=1, `valley`=0 and `setpoint_mv`=200.
- R9: In oscillator mode, `vco_thresh_mv` = 6500 − floor(10·fb_mv/3), saturating at 0. It is 5500 when fb_mv < 300.
- R10: In every valley mode `vco_thresh_mv`=0, `vco_mode`=0 and exactly one `valley` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_start | input | 1 | Evaluate fb_mv at this edge (start of switching cycle) |
| fb_mv | input | 12 | Feedback level, millivolts, unsigned |
| valley | output | 4 | One-hot valley select, bit 0 = 1st valley |
| vco_mode | output | 1 | Oscillator (frequency foldback) mode active |
| setpoint_mv | output | 10 | Peak-current setpoint, millivolts |
| vco_thresh_mv | output | 13 | Oscillator charge threshold, millivolts |

## Verification
A single evaluation can both step the mode and recompute the setpoint and threshold. In that case the new values must be derived from the new mode, not the old one. The bench provokes this on the entries to and exits from oscillator mode (4th valley at 799, oscillator at 3000). It expects a setpoint of 200 and a nonzero threshold on the first edge in oscillator mode. On the first edge back in a valley mode it expects fb/4 and a zero threshold. A large jump in the sample also coincides with the one-step limit. That is judged by expecting the neighbouring mode only, over a descent from the 1st valley at 100 mV and a climb back at 3600 mV.

// File: rtl/vls_pkg.sv
package vls_pkg;

    typedef enum logic [2:0] {
        SEL_V1  = 3'd0,
        SEL_V2  = 3'd1,
        SEL_V3  = 3'd2,
        SEL_V4  = 3'd3,
        SEL_VCO = 3'd4
    } vsel_e;

    // falling levels (mV), strict less-than
    localparam int unsigned FALL_V1 = 1400;
    localparam int unsigned FALL_V2 = 1200;
    localparam int unsigned FALL_V3 = 900;
    localparam int unsigned FALL_V4 = 800;
    // rising levels (mV), strict greater-than
    localparam int unsigned RISE_VCO = 1400;
    localparam int unsigned RISE_V4  = 1600;
    localparam int unsigned RISE_V3  = 1800;
    localparam int unsigned RISE_V2  = 2000;

    localparam int unsigned SP_CEIL   = 800;
    localparam int unsigned SP_FROZEN = 200;
    localparam int unsigned TH_BASE   = 6500;
    localparam int unsigned TH_CLAMP  = 5500;
    localparam int unsigned FB_FLOOR  = 300;

    typedef struct packed {
        logic [3:0] onehot;
        logic       osc;
    } mode_out_t;

    function automatic vsel_e step_sel(vsel_e cur, int unsigned fb);
        vsel_e nxt;
        nxt = cur;
        case (cur)
            SEL_V1:  if (fb < FALL_V1) nxt = SEL_V2;
            SEL_V2:  if (fb < FALL_V2) nxt = SEL_V3;
                     else if (fb > RISE_V2) nxt = SEL_V1;
            SEL_V3:  if (fb < FALL_V3) nxt = SEL_V4;
                     else if (fb > RISE_V3) nxt = SEL_V2;
            SEL_V4:  if (fb < FALL_V4) nxt = SEL_VCO;
                     else if (fb > RISE_V4) nxt = SEL_V3;
            SEL_VCO: if (fb > RISE_VCO) nxt = SEL_V4;
            default: nxt = SEL_V1;
        endcase
        return nxt;
    endfunction

    function automatic int unsigned valley_setpoint(int unsigned fb);
        int unsigned q;
        q = fb / 4;
        return (q > SP_CEIL) ? SP_CEIL : q;
    endfunction

    function automatic int unsigned osc_threshold(int unsigned fb);
        int unsigned drop;
        if (fb < FB_FLOOR) return TH_CLAMP;
        drop = (10 * fb) / 3;
        return (drop >= TH_BASE) ? 0 : (TH_BASE - drop);
    endfunction

endpackage

// File: rtl/vls_mode_fsm.sv
module vls_mode_fsm
    import vls_pkg::*;
#(
    parameter int FB_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            eval,
    input  logic [FB_W-1:0] fb,
    output vsel_e           sel_d,
    output vsel_e           sel_q
);

    always_comb begin
        sel_d = sel_q;
        if (eval) sel_d = step_sel(sel_q, 32'(fb));
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= SEL_V1;
        else     sel_q <= sel_d;
    end

    // R5: any change of mode is to a neighbour
    p_single_step_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_q != $past(sel_q)) |->
        ((int'(sel_q) - int'($past(sel_q)) == 1) || (int'($past(sel_q)) - int'(sel_q) == 1)));

    // R2: mode held when no evaluation requested
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !eval |=> $stable(sel_q));

endmodule

// File: rtl/vls_level_calc.sv
module vls_level_calc
    import vls_pkg::*;
#(
    parameter int FB_W = 12,
    parameter int SP_W = 10,
    parameter int TH_W = 13,
    parameter int NV   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            eval,
    input  vsel_e           sel_d,
    input  logic [FB_W-1:0] fb,
    output logic [NV-1:0]   valley,
    output logic            osc,
    output logic [SP_W-1:0] sp,
    output logic [TH_W-1:0] th
);

    logic [NV-1:0] onehot_d;
    logic          osc_d;
    logic [SP_W-1:0] sp_d;
    logic [TH_W-1:0] th_d;

    genvar gi;
    generate
        for (gi = 0; gi < NV; gi++) begin : g_bit
            assign onehot_d[gi] = (int'(sel_d) == gi);
        end
    endgenerate

    assign osc_d = (sel_d == SEL_VCO);

    always_comb begin
        if (osc_d) begin
            sp_d = SP_W'(SP_FROZEN);
            th_d = TH_W'(osc_threshold(32'(fb)));
        end else begin
            sp_d = SP_W'(valley_setpoint(32'(fb)));
            th_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valley <= NV'(1);
            osc    <= 1'b0;
            sp     <= '0;
            th     <= '0;
        end else if (eval) begin
            valley <= onehot_d;
            osc    <= osc_d;
            sp     <= sp_d;
            th     <= th_d;
        end
    end

    // R10: exactly one of the valley bits or the oscillator flag
    p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        ($countones(valley) + 32'(osc)) == 1);

    // R7: setpoint never beyond its ceiling
    p_sp_ceiling_r7: assert property (@(posedge clk) disable iff (rst)
        32'(sp) <= SP_CEIL);

    // R8: oscillator mode implies frozen setpoint
    p_frozen_sp_r8: assert property (@(posedge clk) disable iff (rst)
        osc |-> (32'(sp) == SP_FROZEN));

    // R10: threshold zero outside oscillator mode
    p_th_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !osc |-> (th == '0));

    // R2: outputs held when no evaluation
    p_out_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !eval |=> ($stable(sp) && $stable(th) && $stable(valley)));

endmodule

// File: rtl/valley_lockout_sel.sv
module valley_lockout_sel
    import vls_pkg::*;
#(
    parameter int FB_W = 12,
    parameter int SP_W = 10,
    parameter int TH_W = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cycle_start,
    input  logic [FB_W-1:0] fb_mv,
    output logic [3:0]      valley,
    output logic            vco_mode,
    output logic [SP_W-1:0] setpoint_mv,
    output logic [TH_W-1:0] vco_thresh_mv
);

    localparam int NV = 4;

    vsel_e sel_d;
    vsel_e sel_q;

    vls_mode_fsm #(.FB_W(FB_W)) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .eval  (cycle_start),
        .fb    (fb_mv),
        .sel_d (sel_d),
        .sel_q (sel_q)
    );

    vls_level_calc #(.FB_W(FB_W), .SP_W(SP_W), .TH_W(TH_W), .NV(NV)) u_calc (
        .clk    (clk),
        .rst    (rst),
        .eval   (cycle_start),
        .sel_d  (sel_d),
        .fb     (fb_mv),
        .valley (valley),
        .osc    (vco_mode),
        .sp     (setpoint_mv),
        .th     (vco_thresh_mv)
    );

    // R8: registered outputs agree with the mode register
    p_mode_match_r8: assert property (@(posedge clk) disable iff (rst)
        vco_mode == (sel_q == SEL_VCO));

endmodule

// File: tb/valley_lockout_sel_test.sv
module valley_lockout_sel_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cycle_start = 1'b0;
    logic [11:0] fb_mv = '0;
    logic [3:0]  valley;
    logic        vco_mode;
    logic [9:0]  setpoint_mv;
    logic [12:0] vco_thresh_mv;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct {
        logic [3:0]  valley;
        logic        vco;
        int          sp;
        int          th;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // bench mode model: 0..3 valleys, 4 oscillator
    int mdl_mode = 0;
    exp_t last_exp;

    always #2 clk = ~clk;

    valley_lockout_sel uut (
        .clk           (clk),
        .rst           (rst),
        .cycle_start   (cycle_start),
        .fb_mv         (fb_mv),
        .valley        (valley),
        .vco_mode      (vco_mode),
        .setpoint_mv   (setpoint_mv),
        .vco_thresh_mv (vco_thresh_mv)
    );

    function automatic int model_next(int m, int fb);
        if (m == 0) return (fb < 1400) ? 1 : 0;
        if (m == 1) return (fb < 1200) ? 2 : ((fb > 2000) ? 0 : 1);
        if (m == 2) return (fb < 900)  ? 3 : ((fb > 1800) ? 1 : 2);
        if (m == 3) return (fb < 800)  ? 4 : ((fb > 1600) ? 2 : 3);
        return (fb > 1400) ? 3 : 4;
    endfunction

    task automatic check_out(exp_t e);
        n_checks++;
        if (valley !== e.valley || vco_mode !== e.vco ||
            int'(setpoint_mv) != e.sp || int'(vco_thresh_mv) != e.th) begin
            n_fail++;
            $display("FAIL %s: got valley=%b vco=%b sp=%0d th=%0d, expected valley=%b vco=%b sp=%0d th=%0d",
                     e.tag, valley, vco_mode, setpoint_mv, vco_thresh_mv,
                     e.valley, e.vco, e.sp, e.th);
        end
    endtask

    // evaluate one sample; expected result pushed after the edge
    task automatic apply(int fb, string tag);
        exp_t e;
        int q;
        @(negedge clk);
        fb_mv = 12'(fb);
        cycle_start = 1'b1;
        mdl_mode = model_next(mdl_mode, fb);
        e.tag = tag;
        if (mdl_mode == 4) begin
            e.valley = 4'b0000;
            e.vco = 1'b1;
            e.sp = 200;
            if (fb < 300) e.th = 5500;
            else begin
                q = (10 * fb) / 3;
                e.th = (q >= 6500) ? 0 : 6500 - q;
            end
        end else begin
            e.valley = 4'b0001 << mdl_mode;
            e.vco = 1'b0;
            q = fb / 4;
            e.sp = (q > 800) ? 800 : q;
            e.th = 0;
        end
        last_exp = e;
        @(posedge clk);
        #1;
        cycle_start = 1'b0;
        sb.push_back(e);
    endtask

    // change feedback without evaluation: outputs must not move
    task automatic idle(int fb, string tag);
        exp_t e;
        @(negedge clk);
        fb_mv = 12'(fb);
        cycle_start = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        e = last_exp;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check_out(e);
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset values
        last_exp.valley = 4'b0001; last_exp.vco = 1'b0;
        last_exp.sp = 0; last_exp.th = 0; last_exp.tag = "R1 reset";
        check_out(last_exp);
        @(negedge clk);
        rst = 1'b0;

        apply(1500, "R6 stay 1st, R7 sp=375");
        idle(100,   "R2 no eval, no change");
        apply(1400, "R6 equal level keeps 1st");
        apply(1399, "R3 1st->2nd");
        apply(2000, "R6 2nd holds at 2000");
        apply(2001, "R4 2nd->1st");
        apply(100,  "R5 single step to 2nd");
        apply(100,  "R3 2nd->3rd");
        apply(899,  "R3 3rd->4th");
        apply(799,  "R3 R8 R9 4th->osc");
        apply(100,  "R9 clamp 5500");
        apply(500,  "R9 th=4834");
        idle(3000,  "R2 osc held");
        apply(1400, "R6 R9 osc at 1400 th=1834");
        apply(3000, "R4 R5 osc->4th, R10 th=0");
        apply(1600, "R6 4th holds at 1600");
        apply(3600, "R4 4th->3rd, R7 sp clamp 800");
        apply(1801, "R4 3rd->2nd");
        apply(1200, "R6 2nd holds at 1200");
        apply(1199, "R3 2nd->3rd again");
        apply(900,  "R6 3rd holds at 900, R10");
        apply(2500, "R4 R5 3rd->2nd only");
        apply(4095, "R4 2nd->1st, R7 sp clamp");

        // reset mid-run returns to 1st valley
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        last_exp.valley = 4'b0001; last_exp.vco = 1'b0;
        last_exp.sp = 0; last_exp.th = 0; last_exp.tag = "R1 reset again";
        mdl_mode = 0;
        sb.push_back(last_exp);
        @(negedge clk);
        rst = 1'b0;
        apply(1000, "R3 R5 after reset to 2nd");

        repeat (4) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule